// File: doc/BRIEF.md
# Latency Equivalence Stream Checker

This block watches two event streams while a design runs and decides whether they carry the same ordered sequence of informative events. Typically one stream comes from a zero-delay reference model and the other from its latency-insensitive refinement. Each stream is a data word with a valid bit. A cycle with the valid bit low is an absent slot and carries no information, so the two streams may differ freely in timing.

Informative words from each side go into their own small FIFO, which absorbs the skew between the streams. Whenever both FIFOs hold a word, the two head words are compared. Equal heads produce a one-cycle match pulse and advance a match counter. The first unequal pair raises a sticky mismatch flag, and from then on the comparison stops. A word that arrives while its FIFO is full is dropped and sets a sticky overflow flag for that side.

Top module: `lat_eq_checker`

## Requirements
- R1: After reset, match_pulse, mismatch, ovf_a and ovf_b are 0, match_count is 0 and idle is 1.
- R2: An informative word (valid high) is stored at the clock edge that samples it. When both FIFOs hold a word at a clock edge, the two heads are compared on that edge, and on a match match_pulse is high for the one cycle that follows. A pair presented together therefore pulses two edges after it is sampled.
- R3: Cycles with the valid bit low are discarded on each stream independently. Only the order of informative words matters, so streams with different gap patterns still match.
- R4: While one FIFO is empty, the word at the head of the other FIFO is kept, not consumed, until a partner word arrives.
- R5: The first compared pair with unequal data sets mismatch. It stays set until reset.
- R6: Once mismatch is set, match_pulse stays low and match_count does not change, whatever words arrive.
- R7: match_count increases by exactly one on each match_pulse and is otherwise unchanged.
- R8: A valid word arriving while its FIFO already holds FIFO_DEPTH words is dropped and sets that side's overflow flag (ovf_a or ovf_b), which stays set until reset. The words already stored are unaffected.
- R9: idle is high exactly when both FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_valid | input | 1 | Stream A slot holds an informative word |
| a_data | input | DATA_W | Stream A word |
| b_valid | input | 1 | Stream B slot holds an informative word |
| b_data | input | DATA_W | Stream B word |
| match_pulse | output | 1 | One-cycle pulse per matched pair |
| mismatch | output | 1 | Sticky: a compared pair differed |
| ovf_a | output | 1 | Sticky: stream A FIFO overflowed |
| ovf_b | output | 1 | Sticky: stream B FIFO overflowed |
| match_count | output | CNT_W | Number of matched pairs |
| idle | output | 1 | Both FIFOs are empty |

## Verification
A corrupted FIFO pointer or occupancy count shows at the ports within the next compare. The pair is then misaligned, so a spurious mismatch rises, match_count stalls, or idle stays low after both streams have drained. A fault in the compare state shows on the very next pair: a pulse that follows a mismatch, a counter step that is not exactly one, or a flag that clears by itself. Overflow handling is exposed through the words that survive in the full FIFO, because later partner words must still match them in their original order.

// File: rtl/lec_pkg.sv
package lec_pkg;

   // Result of examining the two FIFO heads in one cycle
   typedef enum logic [1:0] {
      CMP_WAIT  = 2'd0,
      CMP_EQUAL = 2'd1,
      CMP_DIFF  = 2'd2,
      CMP_HALT  = 2'd3
   } cmp_result_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lec_fifo.sv
module lec_fifo #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full,
   output logic         overflow
);
   import lec_pkg::*;

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   if (DEPTH < 1) begin : g_bad_depth
      $error("lec_fifo: DEPTH must be at least 1");
   end
   if (W < 1) begin : g_bad_width
      $error("lec_fifo: W must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nx, rd_nx;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == FULL_CNT);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   // Pointer advance: the variant depends on the depth
   if (DEPTH == 1) begin : g_single
      assign wr_nx = '0;
      assign rd_nx = '0;
   end else if (is_pow2(DEPTH)) begin : g_pow2
      assign wr_nx = wr_ptr + 1'b1;
      assign rd_nx = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nx = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nx = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         cnt      <= '0;
         overflow <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_nx;
         if (do_pop)  rd_ptr <= rd_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (push && full) overflow <= 1'b1;
      end
   end

endmodule

// File: rtl/lec_compare.sv
module lec_compare #(
   parameter int unsigned W     = 16,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_rdy,
   input  logic [W-1:0]     a_word,
   input  logic             b_rdy,
   input  logic [W-1:0]     b_word,
   output logic             pop,
   output logic             match_pulse,
   output logic             mismatch,
   output logic [CNT_W-1:0] match_count
);
   import lec_pkg::*;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("lec_compare: CNT_W must be at least 1");
   end

   cmp_result_e res;

   always_comb begin
      if (mismatch)               res = CMP_HALT;
      else if (!(a_rdy && b_rdy)) res = CMP_WAIT;
      else if (a_word == b_word)  res = CMP_EQUAL;
      else                        res = CMP_DIFF;
   end

   // Both heads are consumed together, only while the check is live
   assign pop = (res == CMP_EQUAL) || (res == CMP_DIFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_pulse <= 1'b0;
         mismatch    <= 1'b0;
         match_count <= '0;
      end else begin
         match_pulse <= (res == CMP_EQUAL);
         if (res == CMP_DIFF)  mismatch    <= 1'b1;
         if (res == CMP_EQUAL) match_count <= match_count + 1'b1;
      end
   end

endmodule

// File: rtl/lat_eq_checker.sv
module lat_eq_checker #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned FIFO_DEPTH = 4,
   parameter int unsigned CNT_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_valid,
   input  logic [DATA_W-1:0] a_data,
   input  logic              b_valid,
   input  logic [DATA_W-1:0] b_data,
   output logic              match_pulse,
   output logic              mismatch,
   output logic              ovf_a,
   output logic              ovf_b,
   output logic [CNT_W-1:0]  match_count,
   output logic              idle
);

   localparam int unsigned NSIDE = 2;

   logic              side_valid [NSIDE];
   logic [DATA_W-1:0] side_data  [NSIDE];
   logic [DATA_W-1:0] side_head  [NSIDE];
   logic              side_empty [NSIDE];
   logic              side_full  [NSIDE];
   logic              side_ovf   [NSIDE];
   logic              pop_both;

   assign side_valid[0] = a_valid;
   assign side_valid[1] = b_valid;
   assign side_data[0]  = a_data;
   assign side_data[1]  = b_data;

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      lec_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (side_valid[s]),
         .din      (side_data[s]),
         .pop      (pop_both),
         .dout     (side_head[s]),
         .empty    (side_empty[s]),
         .full     (side_full[s]),
         .overflow (side_ovf[s])
      );
   end

   lec_compare #(.W(DATA_W), .CNT_W(CNT_W)) cmp_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .a_rdy       (!side_empty[0]),
      .a_word      (side_head[0]),
      .b_rdy       (!side_empty[1]),
      .b_word      (side_head[1]),
      .pop         (pop_both),
      .match_pulse (match_pulse),
      .mismatch    (mismatch),
      .match_count (match_count)
   );

   assign ovf_a = side_ovf[0];
   assign ovf_b = side_ovf[1];
   assign idle  = side_empty[0] && side_empty[1];

endmodule

// File: rtl/lec_checker.sv
module lec_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             a_valid,
   input logic             b_valid,
   input logic             match_pulse,
   input logic             mismatch,
   input logic             ovf_a,
   input logic             ovf_b,
   input logic [CNT_W-1:0] match_count
);

   // R5
   mismatch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch |=> mismatch);

   // R6
   no_pulse_after_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch |=> !match_pulse);

   // R7
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_pulse) |-> (match_count == $past(match_count) + 1'b1));

   // R7
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !match_pulse |-> $stable(match_count));

   // R8
   ovf_a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_a |=> ovf_a);

   // R8
   ovf_b_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_b |=> ovf_b);

   // R8
   ovf_a_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_a) |-> $past(a_valid));

   // R8
   ovf_b_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_b) |-> $past(b_valid));

endmodule

bind lat_eq_checker lec_checker #(.CNT_W(CNT_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .a_valid     (a_valid),
   .b_valid     (b_valid),
   .match_pulse (match_pulse),
   .mismatch    (mismatch),
   .ovf_a       (ovf_a),
   .ovf_b       (ovf_b),
   .match_count (match_count)
);

// File: tb/lat_eq_checker_tb_top.sv
module lat_eq_checker_tb_top;

   localparam int CLK_P = 10;
   localparam int DW    = 16;
   localparam int DEP   = 4;
   localparam int CW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          a_valid = 1'b0, b_valid = 1'b0;
   logic [DW-1:0] a_data = '0, b_data = '0;
   logic          match_pulse, mismatch, ovf_a, ovf_b, idle;
   logic [CW-1:0] match_count;

   int n_chk = 0, n_fail = 0;
   int seen = 0;
   logic [DW-1:0] exp_q[$];

   always #(CLK_P/2) clk = ~clk;

   lat_eq_checker #(.DATA_W(DW), .FIFO_DEPTH(DEP), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .a_valid(a_valid), .a_data(a_data),
      .b_valid(b_valid), .b_data(b_data),
      .match_pulse(match_pulse), .mismatch(mismatch),
      .ovf_a(ovf_a), .ovf_b(ovf_b),
      .match_count(match_count), .idle(idle)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive one slot on each stream (called at a falling edge), then wait one cycle
   task automatic drive(input logic av, input int ad, input logic bv, input int bd);
      a_valid = av; a_data = DW'(ad);
      b_valid = bv; b_data = DW'(bd);
      @(negedge clk);
      a_valid = 1'b0; b_valid = 1'b0;
   endtask

   task automatic expect_pair(input int v);
      exp_q.push_back(DW'(v));
   endtask

   task automatic quiet(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // Monitor: every match pulse consumes one expected pair and advances the count
   always @(negedge clk) begin
      if (rst_n && match_pulse) begin
         check("R2 pulse has a pending expected pair", exp_q.size() > 0, 1);
         if (exp_q.size() > 0) void'(exp_q.pop_front());
         seen++;
         check("R7 count after pulse", match_count, seen);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 match_pulse", match_pulse, 0);
      check("R1 mismatch", mismatch, 0);
      check("R1 ovf", {ovf_a, ovf_b}, 0);
      check("R1 count", match_count, 0);
      check("R1 idle", idle, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 pulse timing for a pair presented together
      expect_pair(5);
      drive(1, 5, 1, 5);
      check("R2 no pulse one edge after sampling", match_pulse, 0);
      check("R9 idle low while words are held", idle, 0);
      @(negedge clk);
      check("R2 pulse two edges after sampling", match_pulse, 1);
      @(negedge clk);
      check("R2 pulse lasts one cycle", match_pulse, 0);
      check("R9 idle after drain", idle, 1);

      // R3 different gap patterns on each side
      expect_pair(21); expect_pair(22); expect_pair(23);
      drive(1, 21, 0, 0);
      drive(0, 0, 0, 0);
      drive(1, 22, 1, 21);
      drive(0, 0, 0, 0);
      drive(0, 0, 1, 22);
      drive(1, 23, 0, 0);
      drive(0, 0, 0, 0);
      drive(0, 0, 0, 0);
      drive(0, 0, 1, 23);
      quiet(3);
      check("R3 skewed streams matched", match_count, 4);
      check("R3 no mismatch", mismatch, 0);

      // R4 one side waits many cycles; its head word is held
      expect_pair(40);
      drive(0, 0, 1, 40);
      quiet(6);
      check("R4 no pulse while partner absent", match_count, 4);
      check("R4 held word keeps idle low", idle, 0);
      drive(1, 40, 0, 0);
      quiet(2);
      check("R4 held word matched later", match_count, 5);

      // R8 overflow on stream B: fifth word dropped, the first four survive
      for (int i = 0; i < DEP + 1; i++) drive(0, 0, 1, 60 + i);
      check("R8 ovf_b set", ovf_b, 1);
      check("R8 ovf_a clear", ovf_a, 0);
      for (int i = 0; i < DEP; i++) begin
         expect_pair(60 + i);
         drive(1, 60 + i, 0, 0);
      end
      quiet(3);
      check("R8 stored words intact", match_count, 5 + DEP);
      check("R8 no mismatch from drop", mismatch, 0);
      check("R9 idle after overflow drain", idle, 1);
      check("R8 ovf_b sticky", ovf_b, 1);

      // R5 mismatch, R6 frozen afterwards
      drive(1, 7, 1, 8);
      check("R5 mismatch not yet", mismatch, 0);
      @(negedge clk);
      check("R5 mismatch set", mismatch, 1);
      drive(1, 9, 1, 9);
      drive(1, 10, 1, 10);
      quiet(4);
      check("R6 count frozen", match_count, 5 + DEP);
      check("R6 no pulse", match_pulse, 0);
      check("R5 mismatch sticky", mismatch, 1);
      check("R2 every expected pair seen", exp_q.size(), 0);
      report();
   end

endmodule